// File: doc/BRIEF.md
# Leveled Interrupt Mask Controller

This block decides, at each instruction boundary, whether one of several prioritized interrupt requests may be taken by the CPU. Each request source presents a valid bit and a 3-bit level. Level 0 means no request. Levels 1 to 6 are maskable, and level 7 is non-maskable. A 3-bit mask level register gates acceptance. Taking a request below level 7 raises the mask to one above the taken level. This lets only strictly higher levels nest on top of it.

The CPU also drives four command strobes: set-mask with an operand, disable, software interrupt and return-from-interrupt. Every acceptance saves the mask that was in effect onto an eight-entry save stack. Return-from-interrupt restores the saved value, so nested routines unwind in order. Software interrupts and level-7 requests bypass the mask and leave it as it was.

Vector fetch, context saving and the per-source request latches are handled elsewhere. The acceptance pulse and source index are registered and appear one cycle after the boundary that took them.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the mask level is 7, the save stack is empty, and `overflow_o` and `accept_o` are low.
- R2: A source with `req_valid_i` high and a nonzero level L is eligible when L is at least the current mask level. Requests are sampled only in a cycle with `boundary_i` high. The acceptance appears as `accept_o` high, for one cycle, in the cycle after that boundary, with the source index on `accept_src_o` and `accept_soft_o` low.
- R3: Accepting a hardware request of level L below 7 sets the mask level to L+1 in the same cycle that `accept_o` rises.
- R4: Disable (`di_i`) sets the mask level to 7. Set-mask (`ei_i`) sets it to `ei_level_i`, for any value from 0 to 7. The new mask is visible on `mask_o` one cycle later. A boundary in the same cycle is still judged against the old mask.
- R5: A level-7 request is accepted even when the mask level is 7. Its acceptance does not raise the mask.
- R6: A software interrupt (`swi_i`) is accepted whatever the mask level, and leaves the mask unchanged. It is reported as `accept_o` high with `accept_soft_o` high and `accept_src_o` equal to 0. No hardware request is taken in the same cycle.
- R7: When several sources are eligible, the one with the highest level wins. A tie goes to the lowest source index.
- R8: Every acceptance pushes the mask that applies once that cycle's command has taken effect. Return-from-interrupt (`reti_i`) pops the most recent entry into the mask, in last-in first-out order.
- R9: The save stack holds 8 entries. A push while it is full is dropped and sets `overflow_o`, which stays high until reset. A pop from an empty stack leaves the mask unchanged.
- R10: When more than one command strobe is high, only the highest-priority one acts. From highest to lowest, the order is return, software interrupt, disable, set-mask.
- R11: When a hardware acceptance falls in the same cycle as a command, the pushed value is the mask after the command. For return, the popped value is the one pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_SRC | Request valid per source |
| req_level_i | input | NUM_SRC*3 | Request level per source, source i at bits [3i+2:3i] |
| boundary_i | input | 1 | Instruction boundary strobe |
| ei_i | input | 1 | Set-mask command |
| ei_level_i | input | 3 | Operand of the set-mask command |
| di_i | input | 1 | Disable command (mask to 7) |
| swi_i | input | 1 | Software interrupt command |
| reti_i | input | 1 | Return-from-interrupt command |
| accept_o | output | 1 | Acceptance pulse |
| accept_src_o | output | $clog2(NUM_SRC) | Index of the accepted source |
| accept_soft_o | output | 1 | The acceptance is a software interrupt |
| mask_o | output | 3 | Current mask level |
| overflow_o | output | 1 | Sticky save-stack overflow |

## Verification
A hardware acceptance at a boundary can coincide with a CPU command in the same cycle. The bench drives a boundary with an eligible request together with set-mask, disable, return or software interrupt, both in directed cases and in a long random mix. The behavioural model judges these cycles as follows. Eligibility uses the mask from before the command. The pushed entry is the mask after the command, and a software interrupt pre-empts the hardware take. Later returns then expose any wrong saved value on `mask_o`.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = '1;
endpackage

// File: rtl/irq_lvl_arbiter.sv
module irq_lvl_arbiter
  import irq_lvl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SRC_W   = 3
) (
  input  logic [NUM_SRC-1:0]       valid_i,
  input  logic [NUM_SRC*LVL_W-1:0] level_i,
  input  lvl_t                     mask_i,
  output logic                     hit_o,
  output logic [SRC_W-1:0]         src_o,
  output lvl_t                     level_o
);
  lvl_t                lvl   [NUM_SRC];
  logic [NUM_SRC-1:0]  elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign lvl[g]  = level_i[g*LVL_W +: LVL_W];
    // level 0 is no request; top level ignores the mask
    assign elig[g] = valid_i[g] && (lvl[g] != '0) &&
                     ((lvl[g] >= mask_i) || (lvl[g] == LVL_TOP));
  end

  always_comb begin
    level_o = '0;
    src_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      // strict compare keeps the lowest index on ties
      if (elig[i] && (lvl[i] > level_o)) begin
        level_o = lvl[i];
        src_o   = SRC_W'(i);
      end
    end
    hit_o = (level_o != '0);
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_lvl_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  lvl_t data_i,
  output lvl_t top_o,
  output logic nonempty_o,
  output logic overflow_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lvl_t             mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [IDX_W-1:0] top_idx, wr_idx;
  logic             full;

  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign nonempty_o = (cnt_q != '0);
  assign top_idx    = IDX_W'(cnt_q - 1'b1);
  assign wr_idx     = IDX_W'(cnt_q);
  assign top_o      = mem_q[top_idx];
  assign overflow_o = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && pop_i && nonempty_o) begin
      mem_q[top_idx] <= data_i;  // pop then push in one cycle
    end else if (push_i) begin
      if (full) ovf_q <= 1'b1;
      else begin
        mem_q[wr_idx] <= data_i;
        cnt_q         <= cnt_q + 1'b1;
      end
    end else if (pop_i && nonempty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 8,
  parameter int unsigned STACK_DEPTH = 8,
  localparam int unsigned SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       req_valid_i,
  input  logic [NUM_SRC*LVL_W-1:0] req_level_i,
  input  logic                     boundary_i,
  input  logic                     ei_i,
  input  logic [LVL_W-1:0]         ei_level_i,
  input  logic                     di_i,
  input  logic                     swi_i,
  input  logic                     reti_i,
  output logic                     accept_o,
  output logic [SRC_W-1:0]         accept_src_o,
  output logic                     accept_soft_o,
  output logic [LVL_W-1:0]         mask_o,
  output logic                     overflow_o
);
  lvl_t             mask_q, mask_d, eff_mask, arb_lvl, stk_top;
  logic             do_reti, do_swi, do_di, do_ei;
  logic             arb_hit, hw_take, push, stk_nonempty;
  logic [SRC_W-1:0] arb_src;
  logic             acc_q, soft_q;
  logic [SRC_W-1:0] src_q;

  // one command per cycle, by fixed priority
  assign do_reti = reti_i;
  assign do_swi  = swi_i && !reti_i;
  assign do_di   = di_i  && !reti_i && !swi_i;
  assign do_ei   = ei_i  && !reti_i && !swi_i && !di_i;

  irq_lvl_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
    .valid_i (req_valid_i),
    .level_i (req_level_i),
    .mask_i  (mask_q),
    .hit_o   (arb_hit),
    .src_o   (arb_src),
    .level_o (arb_lvl)
  );

  irq_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (do_reti),
    .data_i     (eff_mask),
    .top_o      (stk_top),
    .nonempty_o (stk_nonempty),
    .overflow_o (overflow_o)
  );

  always_comb begin
    if (do_reti)    eff_mask = stk_nonempty ? stk_top : mask_q;
    else if (do_di) eff_mask = LVL_TOP;
    else if (do_ei) eff_mask = ei_level_i;
    else            eff_mask = mask_q;
  end

  assign hw_take = boundary_i && !do_swi && arb_hit;
  assign push    = hw_take || do_swi;
  assign mask_d  = (hw_take && (arb_lvl != LVL_TOP)) ? lvl_t'(arb_lvl + 1'b1)
                                                     : eff_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= LVL_TOP;
      acc_q  <= 1'b0;
      soft_q <= 1'b0;
      src_q  <= '0;
    end else begin
      mask_q <= mask_d;
      acc_q  <= push;
      soft_q <= do_swi;
      src_q  <= hw_take ? arb_src : '0;
    end
  end

  assign accept_o      = acc_q;
  assign accept_soft_o = soft_q;
  assign accept_src_o  = src_q;
  assign mask_o        = mask_q;
endmodule

// File: rtl/irq_lvl_chk.sv
module irq_lvl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       boundary_i,
  input logic       di_i,
  input logic       swi_i,
  input logic       reti_i,
  input logic       accept_o,
  input logic       accept_soft_o,
  input logic [2:0] mask_o,
  input logic       overflow_o
);
  AST_DI_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (di_i && !reti_i && !swi_i && !boundary_i) |=> (mask_o == 3'd7)); // R4

  AST_SWI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swi_i && !reti_i) |=> (mask_o == $past(mask_o))); // R6

  AST_SOFT_IS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_soft_o |-> accept_o); // R6

  AST_NO_SAMPLE_OFF_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boundary_i && !(swi_i && !reti_i)) |=> !accept_o); // R2

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R9
endmodule

bind irq_level_ctrl irq_lvl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .boundary_i    (boundary_i),
  .di_i          (di_i),
  .swi_i         (swi_i),
  .reti_i        (reti_i),
  .accept_o      (accept_o),
  .accept_soft_o (accept_soft_o),
  .mask_o        (mask_o),
  .overflow_o    (overflow_o)
);

// File: tb/sim_irq_level_ctrl.sv
`timescale 1ns/1ps
module sim_irq_level_ctrl;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] req_valid = '0;
  logic [NS*3-1:0] req_level = '0;
  logic          boundary = 0, ei = 0, di = 0, swi = 0, reti = 0;
  logic [2:0]    ei_level = '0;
  logic          accept, accept_soft, overflow;
  logic [2:0]    accept_src, mask;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  int m_mask;
  int m_stk[$];
  bit m_ovf, m_acc, m_soft;
  int m_src;

  always #2.5 clk = ~clk;

  irq_level_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_level_i(req_level),
    .boundary_i(boundary), .ei_i(ei), .ei_level_i(ei_level), .di_i(di),
    .swi_i(swi), .reti_i(reti), .accept_o(accept), .accept_src_o(accept_src),
    .accept_soft_o(accept_soft), .mask_o(mask), .overflow_o(overflow)
  );

  task automatic model_step();
    int eff, best, idx, lv;
    bit sw, hw;
    sw = swi && !reti;
    if (reti) eff = (m_stk.size() > 0) ? m_stk.pop_back() : m_mask;
    else if (swi) eff = m_mask;
    else if (di) eff = 7;
    else if (ei) eff = int'(ei_level);
    else eff = m_mask;
    best = 0; idx = 0;
    if (boundary && !sw)
      for (int i = 0; i < NS; i++) begin
        lv = int'(req_level[i*3 +: 3]);
        if (req_valid[i] && lv != 0 && (lv >= m_mask || lv == 7) && lv > best) begin
          best = lv; idx = i;
        end
      end
    hw = (best != 0);
    if (hw || sw) begin
      if (m_stk.size() < 8) m_stk.push_back(eff);
      else m_ovf = 1;
    end
    m_mask = (hw && best < 7) ? best + 1 : eff;
    m_acc  = hw || sw;
    m_soft = sw;
    m_src  = hw ? idx : 0;
  endtask

  task automatic compare();
    checks++;
    if (int'(mask) != m_mask || accept != m_acc || accept_soft != m_soft ||
        int'(accept_src) != m_src || overflow != m_ovf) begin
      errors++;
      $display("FAIL %s: mask=%0d acc=%0b src=%0d soft=%0b ovf=%0b expected mask=%0d acc=%0b src=%0d soft=%0b ovf=%0b",
               tag, mask, accept, accept_src, accept_soft, overflow,
               m_mask, m_acc, m_src, m_soft, m_ovf);
    end
  endtask

  task automatic idle();
    req_valid = '0; req_level = '0; boundary = 0;
    ei = 0; di = 0; swi = 0; reti = 0; ei_level = '0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic req(input int s, input int l);
    req_valid[s] = 1'b1;
    req_level[s*3 +: 3] = 3'(l);
  endtask

  task automatic set_ei(input int l);
    ei = 1; ei_level = 3'(l);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_mask = 7; m_ovf = 0; m_acc = 0; m_soft = 0; m_src = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tag = "R1"; compare();
    reti = 1; tick();                        // R9 pop on empty keeps mask
    tag = "R2"; req(3, 6); tick();           // no boundary: not sampled
    tag = "R2"; req(3, 6); boundary = 1; tick(); // 6 < mask 7: refused
    // R4, R2, R3: EI 1 then level-1 request
    tag = "R4"; set_ei(1); tick();
    tag = "R3"; req(2, 1); boundary = 1; tick(); tick();
    reti = 1; tick();
    // R5: DI then level 7
    tag = "R4"; di = 1; tick();
    tag = "R5"; req(5, 7); req(1, 6); boundary = 1; tick(); tick();
    reti = 1; tick();
    // R6: SWI in DI state, also with a concurrent eligible request
    tag = "R6"; swi = 1; tick();
    swi = 1; req(4, 7); boundary = 1; tick(); tick();
    reti = 1; tick(); reti = 1; tick();
    // R8: nesting 3 -> 4 -> 5 and unwind
    tag = "R8"; set_ei(3); tick();
    req(0, 3); boundary = 1; tick();
    req(1, 4); req(0, 3); boundary = 1; tick();
    reti = 1; tick(); reti = 1; tick();
    // R7: priority and tie-break
    tag = "R7"; set_ei(0); tick();
    req(1, 5); req(3, 5); req(6, 2); boundary = 1; tick();
    reti = 1; tick();
    req(7, 4); req(6, 4); boundary = 1; tick();
    reti = 1; tick();
    // R10: command priority
    tag = "R10"; reti = 1; di = 1; tick();
    swi = 1; di = 1; set_ei(2); tick();
    di = 1; set_ei(2); tick();
    reti = 1; tick();
    // R11: command coinciding with an acceptance
    tag = "R11"; set_ei(2); tick();
    set_ei(5); req(2, 3); boundary = 1; tick();
    reti = 1; tick();
    di = 1; req(0, 7); boundary = 1; tick();
    reti = 1; req(3, 6); boundary = 1; tick();
    reti = 1; tick(); reti = 1; tick();
    // R9: overflow by software interrupts
    tag = "R9";
    for (int k = 0; k < 10; k++) begin swi = 1; tick(); end
    for (int k = 0; k < 10; k++) begin reti = 1; tick(); end
    // random mix, collisions of commands and boundaries included
    rst_ni = 1'b0; @(negedge clk); rst_ni = 1'b1;
    m_mask = 7; m_stk.delete(); m_ovf = 0; m_acc = 0; m_soft = 0; m_src = 0;
    tag = "R1"; compare();
    tag = "R2";
    for (int k = 0; k < 3000; k++) begin
      req_valid = NS'($urandom);
      req_level = (NS*3)'({$urandom, $urandom});
      boundary  = ($urandom_range(0, 2) != 0);
      ei = ($urandom_range(0, 5) == 0); ei_level = 3'($urandom);
      di = ($urandom_range(0, 9) == 0);
      swi = ($urandom_range(0, 11) == 0);
      reti = ($urandom_range(0, 4) == 0);
      tick();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule